// File: doc/BRIEF.md
# Twelve-Key Priority Encoder with Digit Display

This block turns the state of a twelve-key telephone keypad into a 4-bit key code. The keypad has the ten digits plus two symbol keys, hash and asterisk. The block is purely combinational, with no clock or storage. When several keys are held at once, one of them is chosen by a fixed priority. A flag reports that some key is down. An enable input gates the whole block, and an enable output marks the state "enabled, nothing pressed", so that a lower-priority encoder further down a chain can take over.

Behind the code, a second stage drives the seven lines of a single-digit display. Digits show their usual numerals, hash shows an H and asterisk shows a P-like glyph. The display goes dark whenever no valid key is being reported.

Key input bit `i` belongs to digit `i` for `i` = 0..9. Bit 10 is hash and bit 11 is asterisk.

Top module: `keypad_encoder`

## Requirements
- R1: With `ena_in` high and only digit key `i` (0..9) held, `code` equals `i` in binary.
- R2: With `ena_in` high and only the hash key (bit 10) held, `code` is 1010. With only the asterisk key (bit 11) held, `code` is 1011.
- R3: When several keys are held with `ena_in` high, `code` reports the highest-numbered held key: asterisk, then hash, then 9 down to 0.
- R4: `any_key` is high exactly when `ena_in` is high and at least one key bit is high.
- R5: With `ena_in` low, `code`, `any_key`, `ena_out` and `seg` are all zero, whatever the keys do.
- R6: `ena_out` is high exactly when `ena_in` is high and no key is held. It is never high together with `any_key`.
- R7: With `ena_in` high and no key held, `code` is 0000 and `any_key` is low. `any_key` is what tells this idle case apart from a real key 0.
- R8: While `any_key` is high and `code` is 0..9, `seg` (bit 6 = segment a down to bit 0 = segment g, active high) shows the standard numeral: 0→1111110, 1→0110000, 2→1101101, 3→1111001, 4→0110011, 5→1011011, 6→1011111, 7→1110000, 8→1111111, 9→1111011.
- R9: While `any_key` is high, code 10 shows H (0110111) and code 11 shows P (1100111).
- R10: While `any_key` is low, `seg` is 0000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| keys | input | 12 | Key lines, active high; bits 0..9 digits, 10 hash, 11 asterisk |
| ena_in | input | 1 | Block enable, active high |
| code | output | 4 | Code of the winning key |
| any_key | output | 1 | High while enabled and some key is held |
| ena_out | output | 1 | High while enabled and no key is held |
| seg | output | 7 | Display segments a..g in bits 6..0, active high |

## Verification
Priority resolution and enable gating act on the same input vector. A set of simultaneous presses can therefore meet a low enable, and the gate must then suppress the winner that the resolver has already picked. The bench provokes this by sweeping every one of the 4096 key combinations under both enable levels. The expected winner is computed by scanning the key bits from the top, and every output is judged against that scan. The combinations that hold key 0 and the all-released combination are compared side by side, which separates the two cases where the code is zero.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_DARK = 7'b0000000;

    // Glyph lookup; bit 6 = segment a, bit 0 = segment g.
    function automatic seg_t glyph_of(input logic [3:0] value);
        seg_t pattern;
        unique case (value)
            4'd0:    pattern = 7'b1111110;
            4'd1:    pattern = 7'b0110000;
            4'd2:    pattern = 7'b1101101;
            4'd3:    pattern = 7'b1111001;
            4'd4:    pattern = 7'b0110011;
            4'd5:    pattern = 7'b1011011;
            4'd6:    pattern = 7'b1011111;
            4'd7:    pattern = 7'b1110000;
            4'd8:    pattern = 7'b1111111;
            4'd9:    pattern = 7'b1111011;
            4'd10:   pattern = 7'b0110111;   // H for hash
            4'd11:   pattern = 7'b1100111;   // P for asterisk
            default: pattern = SEG_DARK;
        endcase
        return pattern;
    endfunction

endpackage

// File: rtl/key_prio.sv
module key_prio #(
    parameter int N = 12,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] keys_i,
    output logic [W-1:0] code_o,
    output logic         hit_o
);
    // Ascending scan: a later (higher) index overrides a lower one.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (keys_i[i]) begin
                code_o = W'(i);
            end
        end
        hit_o = |keys_i;
    end
endmodule

// File: rtl/enable_gate.sv
module enable_gate #(
    parameter int W = 4
) (
    input  logic         ena_i,
    input  logic [W-1:0] raw_code_i,
    input  logic         raw_hit_i,
    output logic [W-1:0] code_o,
    output logic         gs_o,
    output logic         eo_o
);
    always_comb begin
        code_o = ena_i ? raw_code_i : '0;
        gs_o   = ena_i & raw_hit_i;
        eo_o   = ena_i & ~raw_hit_i;
    end
endmodule

// File: rtl/seg_stage.sv
module seg_stage
    import keypad_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] code_i,
    input  logic         gs_i,
    output seg_t         seg_o
);
    seg_t glyph;

    always_comb begin
        glyph = glyph_of(4'(code_i));
    end

    // Per-segment blanking gate.
    for (genvar s = 0; s < 7; s++) begin : g_blank
        assign seg_o[s] = glyph[s] & gs_i;
    end
endmodule

// File: rtl/keypad_encoder.sv
module keypad_encoder #(
    parameter  int NKEYS  = 12,
    localparam int CODE_W = $clog2(NKEYS)
) (
    input  logic [NKEYS-1:0]  keys,
    input  logic              ena_in,
    output logic [CODE_W-1:0] code,
    output logic              any_key,
    output logic              ena_out,
    output logic [6:0]        seg
);
    logic [CODE_W-1:0] raw_code;
    logic              raw_hit;

    key_prio #(.N(NKEYS), .W(CODE_W)) prio_i (
        .keys_i (keys),
        .code_o (raw_code),
        .hit_o  (raw_hit)
    );

    enable_gate #(.W(CODE_W)) gate_i (
        .ena_i      (ena_in),
        .raw_code_i (raw_code),
        .raw_hit_i  (raw_hit),
        .code_o     (code),
        .gs_o       (any_key),
        .eo_o       (ena_out)
    );

    seg_stage #(.W(CODE_W)) disp_i (
        .code_i (code),
        .gs_i   (any_key),
        .seg_o  (seg)
    );
endmodule

// File: rtl/keypad_encoder_chk.sv
module keypad_encoder_chk #(
    parameter  int NKEYS  = 12,
    localparam int CODE_W = $clog2(NKEYS)
) (
    input logic [NKEYS-1:0]  keys,
    input logic              ena_in,
    input logic [CODE_W-1:0] code,
    input logic              any_key,
    input logic              ena_out,
    input logic [6:0]        seg
);
    always_comb begin
        if (!$isunknown({keys, ena_in, code, any_key, ena_out, seg})) begin
            if (!ena_in) begin
                AST_DISABLED_QUIET: assert (code == '0 && !any_key && !ena_out && seg == '0); // R5
            end
            AST_EO_GS_EXCLUSIVE: assert (!(any_key && ena_out)); // R6
            AST_GS_FOLLOWS_KEYS: assert (any_key == (ena_in && (keys != '0))); // R4
            if (!any_key) begin
                AST_BLANK_WHEN_IDLE: assert (seg == '0); // R10
                AST_IDLE_CODE_ZERO: assert (code == '0); // R7
            end
            if (any_key && keys[NKEYS-1]) begin
                AST_TOP_KEY_WINS: assert (code == CODE_W'(NKEYS-1)); // R3
            end
        end
    end
endmodule

bind keypad_encoder keypad_encoder_chk #(.NKEYS(NKEYS)) chk_i (
    .keys    (keys),
    .ena_in  (ena_in),
    .code    (code),
    .any_key (any_key),
    .ena_out (ena_out),
    .seg     (seg)
);

// File: tb/keypad_encoder_tb_top.sv
module keypad_encoder_tb_top;

    logic        clk = 1'b0;
    logic [11:0] keys;
    logic        ena_in;
    logic [3:0]  code;
    logic        any_key;
    logic        ena_out;
    logic [6:0]  seg;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    keypad_encoder dut_i (
        .keys    (keys),
        .ena_in  (ena_in),
        .code    (code),
        .any_key (any_key),
        .ena_out (ena_out),
        .seg     (seg)
    );

    function automatic logic [6:0] exp_glyph(input int v);
        case (v)
            0:  return 7'b1111110;
            1:  return 7'b0110000;
            2:  return 7'b1101101;
            3:  return 7'b1111001;
            4:  return 7'b0110011;
            5:  return 7'b1011011;
            6:  return 7'b1011111;
            7:  return 7'b1110000;
            8:  return 7'b1111111;
            9:  return 7'b1111011;
            10: return 7'b0110111;
            11: return 7'b1100111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s keys=%b ena=%0b actual=%0d expected=%0d",
                     req, what, keys, ena_in, act, exp);
        end
    endtask

    task automatic judge();
        int  win;
        int  held;
        bit  en;
        string ctag;
        string stag;
        win  = -1;
        held = 0;
        for (int b = 0; b < 12; b++) begin
            if (keys[b]) begin
                win = b;
                held++;
            end
        end
        en = ena_in;
        if (!en)              ctag = "R5";
        else if (held == 0)   ctag = "R7";
        else if (held > 1)    ctag = "R3";
        else if (win >= 10)   ctag = "R2";
        else                  ctag = "R1";
        check(ctag, int'(code), (en && win >= 0) ? win : 0, "code");
        check(en ? "R4" : "R5", int'(any_key), (en && held > 0) ? 1 : 0, "any_key");
        check(en ? "R6" : "R5", int'(ena_out), (en && held == 0) ? 1 : 0, "ena_out");
        if (!en)              stag = "R5";
        else if (held == 0)   stag = "R10";
        else if (win >= 10)   stag = "R9";
        else                  stag = "R8";
        check(stag, int'(seg), (en && held > 0) ? int'(exp_glyph(win)) : 0, "seg");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // Power-on state: everything released and disabled.
        keys   = '0;
        ena_in = 1'b0;
        @(negedge clk);
        judge();   // R5 quiet outputs at start

        // Idle versus key 0, enabled (R7, R1).
        @(posedge clk); ena_in = 1'b1; keys = 12'h000;
        @(negedge clk); judge();
        @(posedge clk); keys = 12'h001;
        @(negedge clk); judge();

        // Full sweep: every combination under both enable levels (R3, R5).
        for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 4096; k++) begin
                @(posedge clk);
                ena_in = e[0];
                keys   = k[11:0];
                @(negedge clk);
                judge();
            end
        end

        // Enable dropped while a multi-key press is held (R5, R3).
        @(posedge clk); ena_in = 1'b1; keys = 12'hC05;
        @(negedge clk); judge();
        @(posedge clk); ena_in = 1'b0;
        @(negedge clk); judge();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule